// File: doc/BRIEF.md
# Memory PHY Bring-Up Sequencer

This block steers the bring-up of a DDR3-class memory PHY. When reset is released it starts the DLL lock phase and the impedance calibration phase together, and it waits until both report completion or are skipped by their bypass inputs. A software trigger repeats the bring-up. That run begins with a soft-reset pulse to the DLL, and it can end with a second soft-reset pulse to the interface timing modules. A run that comes from reset never produces either pulse. When the bring-up has finished, the block raises `init_done`.

After that point the block controls the order of four later steps, each done by an outside engine: SDRAM initialization (code 0), DQS gate training (code 1), read-data-valid training (code 2) and read-eye training (code 3). A step is requested with a one-cycle `step_req` and a code on `step_sel`. A request is accepted only if it names the next step in sequence and no step is running. An accepted step holds its one-hot `step_go` bit high until the engine pulses the matching `step_ack` bit. When all four steps have finished, `phy_ready` rises. The block has no data path, so every pin is a plain control or status level, or a one-cycle pulse.

Top module: `phy_init_seq`

## Requirements
- R1: While `rst_n` is low, `dll_lock_req`, `zcal_req`, `dll_srst`, `itm_srst`, `init_done`, `step_go`, `phy_ready`, `order_err` and `lock_tmo` are all low.
- R2: On the second rising edge after `rst_n` is released, `dll_lock_req` and `zcal_req` rise together. Each request stays high until its phase completes.
- R3: A cycle with `lock_byp` high ends the DLL lock phase as complete, exactly as a `dll_lock_ack` pulse does.
- R4: A cycle with `zcal_byp` high ends the calibration phase as complete, exactly as a `zcal_ack` pulse does.
- R5: A run that starts from reset issues neither soft reset. `init_done` rises once both phases are complete.
- R6: A `sw_start` pulse while `init_done` is high drops `init_done` and `phy_ready` and clears the step progress. It then drives `dll_srst` high for exactly SRST_CYC cycles, and after that restarts both phases.
- R7: On a software run, the value of `itm_rst_sel` that is latched at the trigger selects an `itm_srst` pulse of exactly SRST_CYC cycles. This pulse starts after both phases have completed, and `init_done` rises only after it ends. If the latched value is 0, no `itm_srst` pulse occurs.
- R8: While `init_done` is high, a `step_req` for code equal to the number of steps already completed is accepted. The next cycle, `step_go` shows that code's bit alone. The bit stays high until the matching `step_ack` bit, and then falls.
- R9: Any other `step_req` is ignored: no `step_go` bit changes. It also sets the sticky `order_err` bit, which only reset clears. In particular, DQS gate training (code 1) is refused before SDRAM initialization (code 0) has completed.
- R10: `phy_ready` rises after read-eye training (code 3) completes.
- R11: If the DLL lock phase stays pending for LOCK_TMO cycles, the sticky `lock_tmo` bit is set. A bypass still completes the phase after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sw_start | input | 1 | Software trigger pulse |
| itm_rst_sel | input | 1 | Request timing-module soft reset on software run |
| lock_byp | input | 1 | Skip or end DLL lock phase |
| zcal_byp | input | 1 | Skip or end calibration phase |
| dll_lock_req | output | 1 | DLL lock phase active |
| dll_lock_ack | input | 1 | DLL lock reached |
| zcal_req | output | 1 | Impedance calibration phase active |
| zcal_ack | input | 1 | Calibration finished |
| dll_srst | output | 1 | DLL soft reset pulse |
| itm_srst | output | 1 | Timing-module soft reset pulse |
| init_done | output | 1 | PHY bring-up complete |
| step_req | input | 1 | Training step request pulse |
| step_sel | input | 2 | Step code 0..3 |
| step_go | output | 4 | One-hot active step |
| step_ack | input | 4 | Per-step completion pulse |
| phy_ready | output | 1 | All steps complete |
| order_err | output | 1 | Sticky out-of-order request flag |
| lock_tmo | output | 1 | Sticky DLL lock timeout flag |

## Verification
Phase completion is tried three ways: calibration acknowledged and lock bypassed, lock acknowledged and calibration bypassed, and lock left unanswered past the timeout. These cases separate the ack path, the bypass path and the timeout. The step ordering is driven from a vector table that mixes early, repeated and skipped codes with correct ones, so that accepted and refused requests can be told apart at `step_go`. Software runs are made with and without the timing-module reset selected, and the width of each pulse is measured. A reset run is compared with both, and it must show no pulses at all.

// File: rtl/phy_init_pkg.sv
package phy_init_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LAUNCH,
    SQ_WAIT,
    SQ_ITM,
    SQ_DSR,
    SQ_READY
  } seq_state_t;
endpackage

// File: rtl/phy_phase_trk.sv
// One calibration phase: request held from start until ack or bypass.
module phy_phase_trk (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ack,
  input  logic byp,
  output logic busy,
  output logic done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      done <= 1'b0;
    end else if (busy && (ack || byp)) begin
      busy <= 1'b0;
      done <= 1'b1;
    end
  end
endmodule

// File: rtl/phy_lock_wdog.sv
// Counts cycles of a pending DLL lock phase; sets a sticky flag at the limit.
module phy_lock_wdog #(
  parameter int unsigned LOCK_TMO = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic busy,
  output logic tmo
);
  localparam int unsigned TW = $clog2(LOCK_TMO + 1);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      tmo <= 1'b0;
    end else if (start) begin
      cnt <= '0;
    end else if (busy) begin
      if (cnt == TW'(LOCK_TMO - 1)) tmo <= 1'b1;
      if (cnt != TW'(LOCK_TMO)) cnt <= cnt + 1'b1;
    end
  end

  // R11
  tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> tmo);
endmodule

// File: rtl/phy_srst_pulse.sv
// Fixed-width soft-reset pulse generator.
module phy_srst_pulse #(
  parameter int unsigned SRST_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic pulse,
  output logic last
);
  localparam int unsigned CW = $clog2(SRST_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(SRST_CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign pulse = (cnt != '0);
  assign last  = (cnt == CW'(1));

  // R6 R7
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !start && !last) |=> pulse);
endmodule

// File: rtl/phy_step_order.sv
// Enforces the fixed order of post-init training steps.
module phy_step_order #(
  parameter int unsigned NSTEP = 4,
  localparam int unsigned SEL_W = $clog2(NSTEP),
  localparam int unsigned PW = $clog2(NSTEP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic             req,
  input  logic [SEL_W-1:0] sel,
  input  logic [NSTEP-1:0] ack,
  output logic [NSTEP-1:0] go,
  output logic             ready,
  output logic             err
);
  logic [PW-1:0]    prog;
  logic [SEL_W-1:0] cur;
  logic             busy, all_done, accept, finish;

  assign busy     = (go != '0);
  assign all_done = (prog == PW'(NSTEP));
  assign accept   = en && req && !busy && !all_done && (PW'(sel) == prog);
  assign finish   = busy && ack[cur];
  assign ready    = all_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go   <= '0;
      prog <= '0;
      cur  <= '0;
      err  <= 1'b0;
    end else begin
      if (req && !accept) err <= 1'b1;
      if (clr) begin
        go   <= '0;
        prog <= '0;
      end else if (accept) begin
        go  <= NSTEP'(1) << sel;
        cur <= sel;
      end else if (finish) begin
        go   <= '0;
        prog <= prog + 1'b1;
      end
    end
  end

  // R8
  go_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go != '0) |-> ($onehot0(go) && go[prog[SEL_W-1:0]]));
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

// File: rtl/phy_init_seq.sv
module phy_init_seq
  import phy_init_pkg::*;
#(
  parameter int unsigned SRST_CYC = 8,
  parameter int unsigned LOCK_TMO = 64,
  parameter int unsigned NSTEP    = 4,
  localparam int unsigned SEL_W   = $clog2(NSTEP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_start,
  input  logic             itm_rst_sel,
  input  logic             lock_byp,
  input  logic             zcal_byp,
  output logic             dll_lock_req,
  input  logic             dll_lock_ack,
  output logic             zcal_req,
  input  logic             zcal_ack,
  output logic             dll_srst,
  output logic             itm_srst,
  output logic             init_done,
  input  logic             step_req,
  input  logic [SEL_W-1:0] step_sel,
  output logic [NSTEP-1:0] step_go,
  input  logic [NSTEP-1:0] step_ack,
  output logic             phy_ready,
  output logic             order_err,
  output logic             lock_tmo
);
  seq_state_t state, nxt;
  logic sw_q, itm_q;
  logic ph_start, lk_done, zc_done, both_done;
  logic dsr_start, dsr_last, itm_start, itm_last, sw_go;

  assign ph_start  = (state == SQ_LAUNCH);
  assign both_done = lk_done && zc_done;
  assign sw_go     = (state == SQ_READY) && sw_start;
  assign dsr_start = sw_go;
  assign itm_start = (state == SQ_WAIT) && both_done && sw_q && itm_q;
  assign init_done = (state == SQ_READY);

  always_comb begin
    nxt = state;
    unique case (state)
      SQ_IDLE:   nxt = SQ_LAUNCH;
      SQ_LAUNCH: nxt = SQ_WAIT;
      SQ_WAIT:   if (both_done) nxt = (sw_q && itm_q) ? SQ_ITM : SQ_READY;
      SQ_ITM:    if (itm_last) nxt = SQ_READY;
      SQ_READY:  if (sw_start) nxt = SQ_DSR;
      SQ_DSR:    if (dsr_last) nxt = SQ_LAUNCH;
      default:   nxt = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      sw_q  <= 1'b0;
      itm_q <= 1'b0;
    end else begin
      state <= nxt;
      if (sw_go) begin
        sw_q  <= 1'b1;
        itm_q <= itm_rst_sel;
      end
    end
  end

  phy_phase_trk u_lock (
    .clk(clk), .rst_n(rst_n), .start(ph_start),
    .ack(dll_lock_ack), .byp(lock_byp),
    .busy(dll_lock_req), .done(lk_done)
  );

  phy_phase_trk u_zcal (
    .clk(clk), .rst_n(rst_n), .start(ph_start),
    .ack(zcal_ack), .byp(zcal_byp),
    .busy(zcal_req), .done(zc_done)
  );

  phy_lock_wdog #(.LOCK_TMO(LOCK_TMO)) u_wdog (
    .clk(clk), .rst_n(rst_n), .start(ph_start),
    .busy(dll_lock_req), .tmo(lock_tmo)
  );

  phy_srst_pulse #(.SRST_CYC(SRST_CYC)) u_dsr (
    .clk(clk), .rst_n(rst_n), .start(dsr_start),
    .pulse(dll_srst), .last(dsr_last)
  );

  phy_srst_pulse #(.SRST_CYC(SRST_CYC)) u_itm (
    .clk(clk), .rst_n(rst_n), .start(itm_start),
    .pulse(itm_srst), .last(itm_last)
  );

  phy_step_order #(.NSTEP(NSTEP)) u_steps (
    .clk(clk), .rst_n(rst_n), .en(init_done), .clr(sw_go),
    .req(step_req), .sel(step_sel), .ack(step_ack),
    .go(step_go), .ready(phy_ready), .err(order_err)
  );

  // R5
  hw_no_srst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_q |-> (!dll_srst && !itm_srst));
  // R7
  init_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (lk_done && zc_done && !itm_srst && !dll_srst));
  // R2
  phase_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dll_lock_req) |-> zcal_req);
endmodule

// File: tb/sim_phy_init_seq.sv
module sim_phy_init_seq;
  localparam int SRST = 6;
  localparam int TMO  = 40;

  logic clk = 1'b0;
  logic rst_n, sw_start, itm_rst_sel, lock_byp, zcal_byp;
  logic dll_lock_ack, zcal_ack, step_req;
  logic [1:0] step_sel;
  logic [3:0] step_ack;
  logic dll_lock_req, zcal_req, dll_srst, itm_srst, init_done;
  logic [3:0] step_go;
  logic phy_ready, order_err, lock_tmo;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit saw_srst = 0;
  bit saw_itm = 0;

  always #5 clk = ~clk;

  phy_init_seq #(.SRST_CYC(SRST), .LOCK_TMO(TMO), .NSTEP(4)) u0 (
    .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .itm_rst_sel(itm_rst_sel),
    .lock_byp(lock_byp), .zcal_byp(zcal_byp),
    .dll_lock_req(dll_lock_req), .dll_lock_ack(dll_lock_ack),
    .zcal_req(zcal_req), .zcal_ack(zcal_ack),
    .dll_srst(dll_srst), .itm_srst(itm_srst), .init_done(init_done),
    .step_req(step_req), .step_sel(step_sel), .step_go(step_go),
    .step_ack(step_ack), .phy_ready(phy_ready), .order_err(order_err),
    .lock_tmo(lock_tmo)
  );

  // {expect_accept, sel}
  localparam logic [2:0] VEC [8] = '{
    3'b0_01, 3'b1_00, 3'b0_11, 3'b0_00,
    3'b1_01, 3'b0_01, 3'b1_10, 3'b1_11
  };

  always @(negedge clk) begin
    if (dll_srst || itm_srst) saw_srst <= 1'b1;
    if (itm_srst) saw_itm <= 1'b1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_sig(input int which, input int lim);
    for (int i = 0; i < lim; i++) begin
      if ((which == 0 && dll_lock_req) || (which == 1 && itm_srst) ||
          (which == 2 && init_done) || (which == 3 && !dll_srst)) break;
      @(negedge clk);
    end
  endtask

  task automatic pulse_width(input bit use_itm, output int w);
    w = 0;
    while ((use_itm ? itm_srst : dll_srst) && w < 100) begin
      w++;
      @(negedge clk);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    int w;
    rst_n = 0; sw_start = 0; itm_rst_sel = 0; lock_byp = 0; zcal_byp = 0;
    dll_lock_ack = 0; zcal_ack = 0; step_req = 0; step_sel = 0; step_ack = 0;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 requests", {30'd0, dll_lock_req, zcal_req}, 0);
    chk("R1 status", {27'd0, dll_srst, itm_srst, init_done, phy_ready, order_err}, 0);
    chk("R1 go/tmo", {27'd0, step_go, lock_tmo}, 0);

    rst_n = 1;
    @(negedge clk);
    chk("R2 not yet", {30'd0, dll_lock_req, zcal_req}, 0);
    @(negedge clk);
    chk("R2 both started", {30'd0, dll_lock_req, zcal_req}, 2'b11);

    zcal_ack = 1; @(negedge clk); zcal_ack = 0;
    chk("R2 zcal ended by ack", zcal_req, 0);
    chk("R3 lock still pending", {30'd0, dll_lock_req, init_done}, 2'b10);
    lock_byp = 1; @(negedge clk); lock_byp = 0;
    chk("R3 lock ended by bypass", dll_lock_req, 0);
    @(negedge clk);
    chk("R5 init_done", init_done, 1);
    chk("R5 no soft reset on hw run", saw_srst, 0);
    chk("R11 no timeout", lock_tmo, 0);
    chk("R9 err clear", order_err, 0);

    // R8 R9 R10 table walk
    foreach (VEC[i]) begin
      step_req = 1; step_sel = VEC[i][1:0];
      @(negedge clk); step_req = 0;
      if (VEC[i][2]) begin
        chk("R8 accepted go", step_go, 4'b1 << VEC[i][1:0]);
        @(negedge clk);
        chk("R8 go held", step_go, 4'b1 << VEC[i][1:0]);
        step_ack = 4'b1 << VEC[i][1:0];
        @(negedge clk); step_ack = 0;
        chk("R8 go dropped", step_go, 0);
      end else begin
        chk("R9 refused go", step_go, 0);
        chk("R9 err set", order_err, 1);
      end
    end
    chk("R10 phy_ready", phy_ready, 1);

    // R6 R7 software run with timing-module reset
    itm_rst_sel = 1; sw_start = 1;
    @(negedge clk); sw_start = 0; itm_rst_sel = 0;
    chk("R6 dll_srst", dll_srst, 1);
    chk("R6 init_done dropped", init_done, 0);
    chk("R6 progress cleared", phy_ready, 0);
    pulse_width(0, w);
    chk("R6 dll_srst width", w, SRST);
    wait_sig(0, 10);
    chk("R6 phases restarted", {30'd0, dll_lock_req, zcal_req}, 2'b11);
    dll_lock_ack = 1; zcal_byp = 1;
    @(negedge clk); dll_lock_ack = 0; zcal_byp = 0;
    chk("R4 zcal ended by bypass", {30'd0, dll_lock_req, zcal_req}, 0);
    chk("R7 itm waits for phases", init_done, 0);
    wait_sig(1, 10);
    chk("R7 itm_srst issued", itm_srst, 1);
    pulse_width(1, w);
    chk("R7 itm_srst width", w, SRST);
    wait_sig(2, 5);
    chk("R7 init_done after itm", init_done, 1);
    chk("R9 err stays sticky", order_err, 1);

    // R7 R11 software run without timing-module reset, lock times out
    saw_itm = 0;
    sw_start = 1; @(negedge clk); sw_start = 0;
    wait_sig(3, 20);
    wait_sig(0, 10);
    zcal_ack = 1; @(negedge clk); zcal_ack = 0;
    repeat (TMO + 5) @(negedge clk);
    chk("R11 lock_tmo set", lock_tmo, 1);
    chk("R11 still waiting", {30'd0, dll_lock_req, init_done}, 2'b10);
    lock_byp = 1; @(negedge clk); lock_byp = 0;
    wait_sig(2, 5);
    chk("R11 bypass rescues", init_done, 1);
    chk("R7 no itm when unselected", saw_itm, 0);
    chk("R11 tmo sticky", lock_tmo, 1);

    summary();
  end
endmodule